// File: doc/BRIEF.md
# Cursor Pattern RAM and Indirect Register Port

This block is the cursor part of a video colour-lookup converter's host interface. A host CPU reaches it through a 4-bit register select with read and write strobes. Through this port it loads a cursor pattern store and programs the cursor position. The store holds 256 bytes when the cursor is 32x32 and 1024 bytes when it is 64x64, at two bits per pixel. The host moves through the store with a byte address that advances after every data-port access. That same address register also acts as the pointer for a small indirect register window. The window is opened by the top bit of a directly addressed control byte.

The host port is a plain register strobe interface, not a stream. There is no valid/ready handshake and no back-pressure. An access is one cycle with `host_wr` or `host_rd` high. Read data appears on `host_rdata` in the cycle after the read strobe and then holds. The block drives the cursor size flag and the on-screen cursor origin, which is the programmed position minus the cursor dimension. The block does not render cursor pixels.

Top module: `cursor_dac_host`

## Requirements
- R1: After reset, `host_rdata` is 0xFF, the cursor is in 32x32 mode (`cur_big`=0), the positions are zero, and the status byte reads as the parameter `STATUS_ID` (0x60 by default; 0x40 is used as a second variant).
- R2: Indirect select 0xA reads 0xFF and ignores writes while bit 7 of the control byte at select 0x6 is clear.
- R3: With the window open, the low byte of the address register picks the indirect target. Index 0 is the read-only status byte, whose writes are ignored. Index 1 is the mode byte, readable and writable. The control byte at select 0x6 reads back as written.
- R4: Indirect index 2 is an extra read/write byte only when `ENHANCED`=1. With `ENHANCED`=0 it reads 0xFF and writes have no effect.
- R5: Select 0x0 writes the low 8 address bits and reads them back. Each read or write at select 0xB transfers the store byte at the current address and then advances the address by one.
- R6: The address wraps with mask 0x0FF in 32x32 mode and with mask 0x3FF in 64x64 mode.
- R7: Mode byte bit 2 selects 64x64. In that mode, a write to select 0x0 or to the mode byte loads address bits 9:8 from mode byte bits 1:0. In 32x32 mode these bits are cleared.
- R8: Positions are 12 bits. Selects 0xC/0xD are X low/high and 0xE/0xF are Y low/high. The high selects keep `wdata[3:0]` and read back as zero-extended.
- R9: `cur_org_x` and `cur_org_y` equal the position minus 32 or minus 64, per the mode, modulo 4096.
- R10: Changing the cursor size leaves the store contents unchanged.
- R11: Selects 0x1-0x5 and 0x7-0x9 read 0xFF and ignore writes.
- R12: `host_rdata` changes only in the cycle after a read strobe. When `host_wr` and `host_rd` are both high, the write is performed and the read is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 4 | Register select |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| cur_big | output | 1 | 1 = 64x64 cursor, 0 = 32x32 |
| cur_org_x | output | 12 | Displayed cursor origin, X |
| cur_org_y | output | 12 | Displayed cursor origin, Y |

## Verification
A wrong mode bit shows at once on `cur_big` and on both origin outputs. A wrong address register shows only at the next read: either the select 0x0 read-back, or a data-port byte that differs from what the bench wrote, one cycle after the strobe. The upper address bits never appear directly. They are exposed by writing distinct bytes at addresses that alias under the 8-bit mask and reading them back. A gating fault in the indirect window shows as a changed mode or as `cur_big` after a write that should have been dropped.

// File: rtl/cdac_pkg.sv
package cdac_pkg;
  localparam logic [3:0] SEL_INDEX   = 4'h0;
  localparam logic [3:0] SEL_CTRL    = 4'h6;
  localparam logic [3:0] SEL_WINDOW  = 4'hA;
  localparam logic [3:0] SEL_PATTERN = 4'hB;
  localparam logic [3:0] SEL_XLO     = 4'hC;
  localparam logic [3:0] SEL_XHI     = 4'hD;
  localparam logic [3:0] SEL_YLO     = 4'hE;
  localparam logic [3:0] SEL_YHI     = 4'hF;

  localparam logic [7:0] WIN_STATUS = 8'h00;
  localparam logic [7:0] WIN_MODE   = 8'h01;
  localparam logic [7:0] WIN_EXTRA  = 8'h02;

  localparam int MODE_BIG_BIT = 2;

  function automatic logic sel_mapped(input logic [3:0] s);
    return (s == SEL_INDEX) || (s == SEL_CTRL) || (s >= SEL_WINDOW);
  endfunction
endpackage

// File: rtl/cdac_index.sv
module cdac_index #(
  parameter int AW = 10,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          big,
  input  logic [AW-LW-1:0] mode_hi,
  input  logic          idx_wr,
  input  logic [LW-1:0] idx_wdata,
  input  logic          mode_ld,
  input  logic          mode_big_new,
  input  logic [AW-LW-1:0] mode_hi_new,
  input  logic          step,
  output logic [AW-1:0] idx
);
  localparam int HW = AW - LW;

  logic [AW-1:0] wrap_mask;
  logic [HW-1:0] hi_on_idx;
  logic [HW-1:0] hi_on_mode;

  always_comb begin
    wrap_mask  = big ? {AW{1'b1}} : {{HW{1'b0}}, {LW{1'b1}}};
    hi_on_idx  = big ? mode_hi : '0;
    hi_on_mode = mode_big_new ? mode_hi_new : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       idx <= '0;
    else if (idx_wr)  idx <= {hi_on_idx, idx_wdata};
    else if (mode_ld) idx <= {hi_on_mode, idx[LW-1:0]};
    else if (step)    idx <= (idx + 1'b1) & wrap_mask;
  end

  // R6
  small_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !big |-> idx[AW-1:LW] == '0);

  // R5
  step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !idx_wr && !mode_ld) |=> idx[LW-1:0] == $past(idx[LW-1:0]) + 1'b1);
endmodule

// File: rtl/cdac_ctrl_regs.sv
module cdac_ctrl_regs
  import cdac_pkg::*;
#(
  parameter bit ENHANCED = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  logic       win_wr,
  input  logic [7:0] win_idx,
  input  logic [7:0] wdata,
  output logic [7:0] ctrl,
  output logic [7:0] mode,
  output logic [7:0] extra,
  output logic       win_open,
  output logic       mode_ld
);
  assign win_open = ctrl[7];
  assign mode_ld  = win_wr && win_open && (win_idx == WIN_MODE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
      mode <= '0;
    end else begin
      if (ctrl_wr) ctrl <= wdata;
      if (mode_ld) mode <= wdata;
    end
  end

  generate
    if (ENHANCED) begin : g_extra
      always_ff @(posedge clk) begin
        if (!rst_n) extra <= '0;
        else if (win_wr && win_open && (win_idx == WIN_EXTRA)) extra <= wdata;
      end
    end else begin : g_no_extra
      assign extra = '0;
    end
  endgenerate

  // R2
  win_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr && !ctrl[7]) |=> $stable(mode));
endmodule

// File: rtl/cdac_cursor_ram.sv
module cdac_cursor_ram #(
  parameter int DEPTH = 1024,
  parameter int AW    = 10,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] q
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
  end

  assign q = mem[addr];
endmodule

// File: rtl/cdac_position.sv
module cdac_position #(
  parameter int PW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    wr_sel,
  input  logic [DW-1:0] wdata,
  input  logic [PW-1:0] size,
  output logic [PW-1:0] pos_x,
  output logic [PW-1:0] pos_y,
  output logic [PW-1:0] org_x,
  output logic [PW-1:0] org_y
);
  localparam int HB = PW - DW;

  logic [PW-1:0] pos_a [2];
  logic [PW-1:0] org_a [2];

  generate
    for (genvar a = 0; a < 2; a++) begin : g_axis
      logic [DW-1:0] lo;
      logic [HB-1:0] hi;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          lo <= '0;
          hi <= '0;
        end else begin
          if (wr_sel[2*a])   lo <= wdata;
          if (wr_sel[2*a+1]) hi <= wdata[HB-1:0];
        end
      end
      assign pos_a[a] = {hi, lo};
      assign org_a[a] = pos_a[a] - size;
    end
  endgenerate

  assign pos_x = pos_a[0];
  assign pos_y = pos_a[1];
  assign org_x = org_a[0];
  assign org_y = org_a[1];

  // R8
  pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel == 4'b0) |=> ($stable(pos_x) && $stable(pos_y)));
endmodule

// File: rtl/cursor_dac_host.sv
module cursor_dac_host
  import cdac_pkg::*;
#(
  parameter bit         ENHANCED  = 1'b1,
  parameter logic [7:0] STATUS_ID = 8'h60,
  parameter int         SMALL_DIM = 32,
  parameter int         BIG_DIM   = 64,
  parameter int         BPP       = 2,
  parameter int         PW        = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    host_sel,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  output logic          cur_big,
  output logic [PW-1:0] cur_org_x,
  output logic [PW-1:0] cur_org_y
);
  localparam int BIG_BYTES   = BIG_DIM * BIG_DIM * BPP / 8;
  localparam int SMALL_BYTES = SMALL_DIM * SMALL_DIM * BPP / 8;
  localparam int AW = $clog2(BIG_BYTES);
  localparam int LW = $clog2(SMALL_BYTES);
  localparam int HW = AW - LW;

  logic          rd_go;
  logic [7:0]    ctrl, mode, extra;
  logic          win_open, mode_ld;
  logic [AW-1:0] idx;
  logic [7:0]    ram_q;
  logic [PW-1:0] size, pos_x, pos_y;
  logic [3:0]    pos_wr;
  logic [7:0]    rd_mux;
  logic          pat_acc;

  assign rd_go   = host_rd && !host_wr;
  assign pat_acc = (host_sel == SEL_PATTERN) && (host_wr || host_rd);
  assign cur_big = mode[MODE_BIG_BIT];
  assign size    = cur_big ? PW'(BIG_DIM) : PW'(SMALL_DIM);

  always_comb begin
    pos_wr = '0;
    if (host_wr) begin
      pos_wr[0] = (host_sel == SEL_XLO);
      pos_wr[1] = (host_sel == SEL_XHI);
      pos_wr[2] = (host_sel == SEL_YLO);
      pos_wr[3] = (host_sel == SEL_YHI);
    end
  end

  cdac_ctrl_regs #(.ENHANCED(ENHANCED)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .ctrl_wr(host_wr && host_sel == SEL_CTRL),
    .win_wr(host_wr && host_sel == SEL_WINDOW),
    .win_idx(idx[7:0]), .wdata(host_wdata),
    .ctrl(ctrl), .mode(mode), .extra(extra),
    .win_open(win_open), .mode_ld(mode_ld)
  );

  cdac_index #(.AW(AW), .LW(LW)) u_index (
    .clk(clk), .rst_n(rst_n), .big(cur_big), .mode_hi(mode[HW-1:0]),
    .idx_wr(host_wr && host_sel == SEL_INDEX), .idx_wdata(host_wdata[LW-1:0]),
    .mode_ld(mode_ld), .mode_big_new(host_wdata[MODE_BIG_BIT]),
    .mode_hi_new(host_wdata[HW-1:0]), .step(pat_acc), .idx(idx)
  );

  cdac_cursor_ram #(.DEPTH(BIG_BYTES), .AW(AW), .DW(8)) u_ram (
    .clk(clk), .we(host_wr && host_sel == SEL_PATTERN),
    .addr(idx), .wd(host_wdata), .q(ram_q)
  );

  cdac_position #(.PW(PW), .DW(8)) u_pos (
    .clk(clk), .rst_n(rst_n), .wr_sel(pos_wr), .wdata(host_wdata),
    .size(size), .pos_x(pos_x), .pos_y(pos_y),
    .org_x(cur_org_x), .org_y(cur_org_y)
  );

  always_comb begin
    rd_mux = 8'hFF;
    case (host_sel)
      SEL_INDEX:   rd_mux = idx[7:0];
      SEL_CTRL:    rd_mux = ctrl;
      SEL_WINDOW:
        if (win_open) begin
          case (idx[7:0])
            WIN_STATUS: rd_mux = STATUS_ID;
            WIN_MODE:   rd_mux = mode;
            WIN_EXTRA:  rd_mux = ENHANCED ? extra : 8'hFF;
            default:    rd_mux = 8'hFF;
          endcase
        end
      SEL_PATTERN: rd_mux = ram_q;
      SEL_XLO:     rd_mux = pos_x[7:0];
      SEL_XHI:     rd_mux = {{(16-PW){1'b0}}, pos_x[PW-1:8]};
      SEL_YLO:     rd_mux = pos_y[7:0];
      SEL_YHI:     rd_mux = {{(16-PW){1'b0}}, pos_y[PW-1:8]};
      default:     rd_mux = 8'hFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     host_rdata <= 8'hFF;
    else if (rd_go) host_rdata <= rd_mux;
  end

  // R11
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && !sel_mapped(host_sel)) |=> host_rdata == 8'hFF);

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_go |=> $stable(host_rdata));

  // R3
  status_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && host_sel == SEL_WINDOW && ctrl[7] && idx[7:0] == WIN_STATUS)
      |=> host_rdata == STATUS_ID);

  // R7
  big_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_sel == SEL_INDEX && cur_big) |=> idx[AW-1:LW] == $past(mode[HW-1:0]));

  generate
    if (!ENHANCED) begin : g_no_extra_chk
      // R4
      extra_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && host_sel == SEL_WINDOW && idx[7:0] == WIN_EXTRA) |=> host_rdata == 8'hFF);
    end
  endgenerate
endmodule

// File: tb/cursor_dac_host_tb.sv
`timescale 1ns/1ps
module cursor_dac_host_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] host_sel = '0;
  logic host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] rdata_a, rdata_b;
  logic big_a, big_b;
  logic [11:0] ox_a, oy_a, ox_b, oy_b;
  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  cursor_dac_host u_dut (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(rdata_a),
    .cur_big(big_a), .cur_org_x(ox_a), .cur_org_y(oy_a));

  cursor_dac_host #(.ENHANCED(1'b0), .STATUS_ID(8'h40)) u_dut_b (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(rdata_b),
    .cur_big(big_b), .cur_org_x(ox_b), .cur_org_y(oy_b));

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] s, input logic [7:0] d);
    @(negedge clk);
    host_sel = s; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] s);
    @(negedge clk);
    host_sel = s; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  // {is_read, select, data_or_expected, requirement}
  localparam int NV = 32;
  localparam logic [16:0] VEC [NV] = '{
    {1'b1, 4'hA, 8'hFF, 4'd2},   // R2 window closed
    {1'b0, 4'hA, 8'h55, 4'd2},   // R2 dropped write
    {1'b0, 4'h6, 8'h80, 4'd3},
    {1'b1, 4'h6, 8'h80, 4'd3},   // R3 control readback
    {1'b0, 4'h0, 8'h01, 4'd3},
    {1'b1, 4'hA, 8'h00, 4'd2},   // R2 mode untouched
    {1'b0, 4'hA, 8'h03, 4'd3},
    {1'b1, 4'hA, 8'h03, 4'd3},   // R3 mode byte
    {1'b0, 4'h0, 8'h00, 4'd3},
    {1'b1, 4'hA, 8'h60, 4'd3},   // R3 status
    {1'b0, 4'hA, 8'h11, 4'd3},
    {1'b1, 4'hA, 8'h60, 4'd3},   // R3 status write ignored
    {1'b0, 4'h0, 8'h02, 4'd4},
    {1'b0, 4'hA, 8'h5A, 4'd4},
    {1'b1, 4'hA, 8'h5A, 4'd4},   // R4 extra byte present
    {1'b1, 4'h3, 8'hFF, 4'd11},  // R11
    {1'b1, 4'h9, 8'hFF, 4'd11},  // R11
    {1'b0, 4'h5, 8'h77, 4'd11},
    {1'b1, 4'h0, 8'h02, 4'd5},   // R5 index readback
    {1'b0, 4'h0, 8'hFE, 4'd5},
    {1'b0, 4'hB, 8'hA1, 4'd5},
    {1'b0, 4'hB, 8'hA2, 4'd5},
    {1'b1, 4'h0, 8'h00, 4'd6},   // R6 8-bit wrap
    {1'b0, 4'h0, 8'hFE, 4'd5},
    {1'b1, 4'hB, 8'hA1, 4'd5},   // R5 pattern read
    {1'b1, 4'hB, 8'hA2, 4'd5},
    {1'b1, 4'h0, 8'h00, 4'd6},
    {1'b0, 4'hC, 8'h34, 4'd8},
    {1'b0, 4'hD, 8'hF2, 4'd8},
    {1'b1, 4'hD, 8'h02, 4'd8},   // R8 high nibble only
    {1'b1, 4'hC, 8'h34, 4'd8},
    {1'b1, 4'h6, 8'h80, 4'd11}   // R11 write to 0x5 left control alone
  };

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rdata", {8'h0, rdata_a}, 16'h00FF);
    check("R1 big", {15'h0, big_a}, 16'h0);
    check("R1 orgx", {4'h0, ox_a}, 16'h0FE0);
    check("R1 orgy", {4'h0, oy_a}, 16'h0FE0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][16]) begin
        rd(VEC[i][15:12]);
        check($sformatf("R%0d vec%0d", VEC[i][3:0], i), {8'h0, rdata_a}, {8'h0, VEC[i][11:4]});
      end else begin
        wr(VEC[i][15:12], VEC[i][11:4]);
      end
    end

    // R9 origin in 32x32 mode
    check("R9 orgx32", {4'h0, ox_a}, 16'h0214);

    // R4 second variant: extra byte absent; R1 per-variant status
    wr(4'h0, 8'h02);
    rd(4'hA);
    check("R4 enhanced", {8'h0, rdata_a}, 16'h005A);
    check("R4 plain", {8'h0, rdata_b}, 16'h00FF);
    wr(4'h0, 8'h00);
    rd(4'hA);
    check("R1 status variant", {8'h0, rdata_b}, 16'h0040);

    // R7 64x64 mode, upper bits from mode byte
    wr(4'h0, 8'h01);
    wr(4'hA, 8'h06);
    check("R7 big", {15'h0, big_a}, 16'h1);
    wr(4'h0, 8'hFF);
    wr(4'hB, 8'hC3);
    wr(4'h0, 8'hFF);
    rd(4'hB);
    check("R7 hi bits", {8'h0, rdata_a}, 16'h00C3);
    check("R9 orgx64", {4'h0, ox_a}, 16'h01F4);

    // R6 10-bit wrap and no 8-bit wrap in 64x64 mode
    wr(4'h0, 8'h01);
    wr(4'hA, 8'h07);
    wr(4'h0, 8'hFF);
    wr(4'hB, 8'h77);
    wr(4'hB, 8'h88);
    wr(4'h0, 8'h01);
    wr(4'hA, 8'h04);
    wr(4'h0, 8'hFF);
    wr(4'hB, 8'h5E);
    wr(4'hB, 8'h6F);
    wr(4'h0, 8'h00);
    rd(4'hB);
    check("R6 wrap64", {8'h0, rdata_a}, 16'h0088);

    // R10 size changes keep contents
    wr(4'h0, 8'h01);
    wr(4'hA, 8'h00);
    check("R10 small", {15'h0, big_a}, 16'h0);
    wr(4'h0, 8'hFE);
    rd(4'hB);
    check("R10 keep32", {8'h0, rdata_a}, 16'h00A1);
    wr(4'h0, 8'h01);
    wr(4'hA, 8'h06);
    wr(4'h0, 8'hFF);
    rd(4'hB);
    check("R10 keep64", {8'h0, rdata_a}, 16'h00C3);

    // R9 negative wrap on Y
    wr(4'hE, 8'h10);
    wr(4'hF, 8'h00);
    check("R9 orgy wrap", {4'h0, oy_a}, 16'h0FD0);

    // R12 write wins over read, data holds
    @(negedge clk);
    host_sel = 4'hC; host_wdata = 8'h99; host_wr = 1'b1; host_rd = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; host_rd = 1'b0;
    check("R12 read dropped", {8'h0, rdata_a}, 16'h00C3);
    rd(4'hC);
    check("R12 write done", {8'h0, rdata_a}, 16'h0099);
    repeat (3) @(negedge clk);
    check("R12 hold", {8'h0, rdata_a}, 16'h0099);

    // R2 closing the window drops mode writes
    wr(4'h6, 8'h00);
    wr(4'h0, 8'h01);
    wr(4'hA, 8'h00);
    check("R2 big kept", {15'h0, big_a}, 16'h1);
    rd(4'hA);
    check("R2 closed read", {8'h0, rdata_a}, 16'h00FF);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule